// File: doc/BRIEF.md
# Chainable 64-Tap FIR Segment

This block is a programmable finite impulse response filter segment with 64 taps. It accepts signed 18-bit samples qualified by a valid strobe. Every accepted sample moves a 64-stage delay line by one stage. The segment then forms the sum of every stage multiplied by its own coefficient. Coefficients are 18-bit signed words held in four banks of 16 words, and a single synchronous write port loads them.

Two identical segments can be joined to act as one 128-tap filter. A 2-bit role input sets each segment's job.

- A segment in the "main" role filters the incoming stream and shows its oldest delay-line stage on a tap-out port.
- A segment in the "secondary" role takes that tap-out, in place of its own sample input, as the feed for its delay line. It returns its partial sum.
- The main segment adds the returned partial sum into its own sum and produces the final output.
- A standalone segment ignores the partial-sum input and gives its own 64-tap result.

In every role the output valid appears a fixed three cycles after the input valid.

Top module: `fir_seg`

## Requirements
- R1: While reset is high, and on the first cycle after it, `y_o`, `y_vld_o`, `psum_o` and `cas_tap_o` are all zero. Reset clears every coefficient and every delay-line stage.
- R2: When `smp_vld_i` is high in cycle t, the matching `y_vld_o` pulse is high for one cycle in cycle t+3 and not in cycle t+2. This latency is the same in standalone and main roles.
- R3: In standalone role (`mode_i` = 2'b00), `y_o` equals the sum over k = 0..63 of c[k]·x[n−k], where x[n] is the newest accepted sample. `psum_i` has no effect on `y_o`.
- R4: A write with `cw_en_i` high stores `cw_data_i` at tap index 16·`cw_addr_i[5:4]` + `cw_addr_i[3:0]`. Bits [5:4] select the bank and bits [3:0] select the word. Tap index 0 multiplies the newest sample.
- R5: After each accepted sample, `cas_tap_o` shows the oldest delay-line stage, which is the sample accepted 63 strobes earlier.
- R6: In main role (`mode_i` = 2'b10), `y_o` equals the segment's own 64-tap sum plus `psum_i`. With a secondary segment attached, this gives a 128-tap filter whose taps 64..127 use the secondary's coefficients.
- R7: In secondary role (`mode_i` = 2'b01), the delay line takes `cas_tap_i` and ignores `smp_i`. `psum_o` carries the segment's own sum from cycle t+2. `y_vld_o` never rises.
- R8: While `en_i` is low, `y_vld_o` stays low and `y_o` holds. The delay line and `psum_o` keep updating.
- R9: The accumulator is 43 bits wide. A full-scale 128-tap result (2^41, from all samples and coefficients equal to −2^17) comes out exactly.
- R10: A cycle with `smp_vld_i` low moves no delay-line stage, whatever `smp_i` carries. `cas_tap_o` holds in such a cycle.
- R11: Role code 2'b11 behaves exactly as standalone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Output enable |
| mode_i | input | 2 | Role: 00 standalone, 01 secondary, 10 main, 11 standalone |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_i | input | 18 | Signed input sample |
| cas_tap_i | input | 18 | Delay-line feed from the main segment (secondary role) |
| cas_tap_o | output | 18 | Oldest delay-line stage, feeds a secondary segment |
| psum_i | input | 43 | Partial sum returned by a secondary segment |
| psum_o | output | 43 | This segment's own 64-tap sum |
| cw_en_i | input | 1 | Coefficient write enable |
| cw_addr_i | input | 6 | Coefficient address: bank in [5:4], word in [3:0] |
| cw_data_i | input | 18 | Signed coefficient value |
| y_o | output | 43 | Filter output |
| y_vld_o | output | 1 | Output valid strobe |

## Verification
The bench builds two instances with the package defaults: 18-bit samples and coefficients, four banks of 16 words, 64 taps and a 43-bit accumulator. It chains them as main and secondary, so every check of the main output also covers the tap-out and the partial-sum return over a 128-deep history. Because the defaults are the real sizes, the bench can reach the full-scale corner: 128 products of −2^17 by −2^17 summing to 2^41. It can also reach a single-coefficient impulse placed in a middle bank, which shows how addresses map to taps.

// File: rtl/fir_seg_pkg.sv
`timescale 1ns/1ps
package fir_seg_pkg;
    parameter int SMP_W      = 18;
    parameter int COEF_W     = 18;
    parameter int BANKS      = 4;
    parameter int BANK_DEPTH = 16;
    localparam int TAPS      = BANKS * BANK_DEPTH;
    localparam int ADDR_W    = $clog2(TAPS);
    localparam int BSEL_W    = $clog2(BANKS);
    localparam int WSEL_W    = $clog2(BANK_DEPTH);
    // Room for twice TAPS full-scale products (chained pair).
    localparam int ACC_W     = SMP_W + COEF_W + $clog2(2 * TAPS);

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [1:0] {
        ROLE_SOLO = 2'b00,
        ROLE_SEC  = 2'b01,
        ROLE_MAIN = 2'b10,
        ROLE_ALT  = 2'b11
    } role_e;

    typedef struct packed {
        logic vld;
        acc_t sum;
    } stage_t;

    function automatic logic role_drives_out(role_e r);
        return r != ROLE_SEC;
    endfunction

    function automatic logic role_adds_return(role_e r);
        return r == ROLE_MAIN;
    endfunction
endpackage

// File: rtl/fir_seg_coef.sv
`timescale 1ns/1ps
module fir_seg_coef
    import fir_seg_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  coef_t             wr_data_i,
    output coef_t             coef_o [TAPS]
);
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        coef_t mem [BANK_DEPTH];
        logic  hit;

        assign hit = wr_en_i && (wr_addr_i[ADDR_W-1 -: BSEL_W] == BSEL_W'(b));

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                for (int i = 0; i < BANK_DEPTH; i++) mem[i] <= '0;
            end else if (hit) begin
                mem[wr_addr_i[WSEL_W-1:0]] <= wr_data_i;
            end
        end

        for (genvar w = 0; w < BANK_DEPTH; w++) begin : g_word
            assign coef_o[b*BANK_DEPTH + w] = mem[w];
        end
    end
endmodule

// File: rtl/fir_seg_line.sv
`timescale 1ns/1ps
module fir_seg_line
    import fir_seg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic shift_i,
    input  smp_t din_i,
    output smp_t tap_o [TAPS]
);
    smp_t stg [TAPS];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < TAPS; i++) stg[i] <= '0;
        end else if (shift_i) begin
            stg[0] <= din_i;
            for (int i = 1; i < TAPS; i++) stg[i] <= stg[i-1];
        end
    end

    assign tap_o = stg;
endmodule

// File: rtl/fir_seg_mac.sv
`timescale 1ns/1ps
module fir_seg_mac
    import fir_seg_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   vld_i,
    input  smp_t   tap_i  [TAPS],
    input  coef_t  coef_i [TAPS],
    output stage_t out_o
);
    acc_t sum_c;

    always_comb begin
        sum_c = '0;
        for (int k = 0; k < TAPS; k++) begin
            sum_c = sum_c + acc_t'(tap_i[k]) * acc_t'(coef_i[k]);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_o <= '0;
        end else begin
            out_o.vld <= vld_i;
            if (vld_i) out_o.sum <= sum_c;
        end
    end
endmodule

// File: rtl/fir_seg.sv
`timescale 1ns/1ps
module fir_seg
    import fir_seg_pkg::*;
(
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     en_i,
    input  logic [1:0]               mode_i,
    input  logic                     smp_vld_i,
    input  logic signed [SMP_W-1:0]  smp_i,
    input  logic signed [SMP_W-1:0]  cas_tap_i,
    output logic signed [SMP_W-1:0]  cas_tap_o,
    input  logic signed [ACC_W-1:0]  psum_i,
    output logic signed [ACC_W-1:0]  psum_o,
    input  logic                     cw_en_i,
    input  logic [ADDR_W-1:0]        cw_addr_i,
    input  logic signed [COEF_W-1:0] cw_data_i,
    output logic signed [ACC_W-1:0]  y_o,
    output logic                     y_vld_o
);
    role_e  role;
    smp_t   line_din;
    smp_t   taps  [TAPS];
    coef_t  coefs [TAPS];
    logic   vld_d1;
    stage_t mac_q;
    acc_t   ret_add;

    assign role     = role_e'(mode_i);
    assign line_din = (role == ROLE_SEC) ? cas_tap_i : smp_i;

    fir_seg_coef u_coef (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (cw_en_i),
        .wr_addr_i (cw_addr_i),
        .wr_data_i (cw_data_i),
        .coef_o    (coefs)
    );

    fir_seg_line u_line (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .shift_i (smp_vld_i),
        .din_i   (line_din),
        .tap_o   (taps)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) vld_d1 <= 1'b0;
        else       vld_d1 <= smp_vld_i;
    end

    fir_seg_mac u_mac (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .vld_i  (vld_d1),
        .tap_i  (taps),
        .coef_i (coefs),
        .out_o  (mac_q)
    );

    assign cas_tap_o = taps[TAPS-1];
    assign psum_o    = mac_q.sum;
    assign ret_add   = role_adds_return(role) ? psum_i : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            y_o     <= '0;
            y_vld_o <= 1'b0;
        end else begin
            y_vld_o <= mac_q.vld && en_i && role_drives_out(role);
            if (mac_q.vld && en_i && role_drives_out(role)) begin
                y_o <= mac_q.sum + ret_add;
            end
        end
    end
endmodule

// File: rtl/fir_seg_chk.sv
`timescale 1ns/1ps
module fir_seg_chk
    import fir_seg_pkg::*;
(
    input logic                    clk_i,
    input logic                    rst_i,
    input logic                    en_i,
    input logic [1:0]              mode_i,
    input logic                    smp_vld_i,
    input logic signed [SMP_W-1:0] cas_tap_o,
    input logic signed [ACC_W-1:0] psum_i,
    input logic signed [ACC_W-1:0] psum_o,
    input logic signed [ACC_W-1:0] y_o,
    input logic                    y_vld_o
);
    p_reset_clear_r1: assert property (@(posedge clk_i)
        rst_i |=> (y_o == '0 && !y_vld_o && psum_o == '0 && cas_tap_o == '0));

    p_latency_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        y_vld_o |-> $past(smp_vld_i, 3));

    p_solo_ignores_ret_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (y_vld_o && ($past(mode_i) == 2'b00)) |-> (y_o == $past(psum_o)));

    p_main_adds_ret_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (y_vld_o && ($past(mode_i) == 2'b10)) |-> (y_o == $past(psum_o) + $past(psum_i)));

    p_sec_silent_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_i == 2'b01) |=> !y_vld_o);

    p_disabled_quiet_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!y_vld_o && $stable(y_o)));

    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !smp_vld_i |=> $stable(cas_tap_o));

    p_alt_as_solo_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (y_vld_o && ($past(mode_i) == 2'b11)) |-> (y_o == $past(psum_o)));
endmodule

bind fir_seg fir_seg_chk u_chk (.*);

// File: tb/fir_seg_bench.sv
`timescale 1ns/1ps
module fir_seg_bench;
    import fir_seg_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst, vld, en, m_cw, s_cw;
    logic [1:0]        mode;
    smp_t              smp;
    logic [ADDR_W-1:0] cw_addr;
    coef_t             cw_data;
    smp_t              m_tap, s_tap;
    acc_t              m_psum, s_psum, m_y, s_y;
    logic              m_yv, s_yv;

    fir_seg u_fir_seg (
        .clk_i(clk), .rst_i(rst), .en_i(en), .mode_i(mode),
        .smp_vld_i(vld), .smp_i(smp), .cas_tap_i('0), .cas_tap_o(m_tap),
        .psum_i(s_psum), .psum_o(m_psum),
        .cw_en_i(m_cw), .cw_addr_i(cw_addr), .cw_data_i(cw_data),
        .y_o(m_y), .y_vld_o(m_yv)
    );

    fir_seg u_fir_seg_sec (
        .clk_i(clk), .rst_i(rst), .en_i(1'b0), .mode_i(2'b01),
        .smp_vld_i(vld), .smp_i(smp), .cas_tap_i(m_tap), .cas_tap_o(s_tap),
        .psum_i('0), .psum_o(s_psum),
        .cw_en_i(s_cw), .cw_addr_i(cw_addr), .cw_data_i(cw_data),
        .y_o(s_y), .y_vld_o(s_yv)
    );

    int     total = 0, bad = 0, sec_pulses = 0;
    bit     done = 1'b0;
    longint hist [2*TAPS];
    longint cm [TAPS];
    longint cs [TAPS];

    typedef struct packed {
        logic [1:0] md;
        logic       ena;
        smp_t       x;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{2'b10, 1'b1,  18'sd1234},  '{2'b10, 1'b1, -18'sd77},
        '{2'b00, 1'b1,  18'sd131071}, '{2'b00, 1'b1, -18'sd131072},
        '{2'b11, 1'b1,  18'sd500},   '{2'b11, 1'b1, -18'sd9000},
        '{2'b10, 1'b0,  18'sd4321},  '{2'b00, 1'b0, -18'sd1},
        '{2'b10, 1'b1,  18'sd0},     '{2'b00, 1'b1,  18'sd65535},
        '{2'b10, 1'b1, -18'sd40000}, '{2'b11, 1'b1,  18'sd17}
    };

    always @(negedge clk) if (s_yv) sec_pulses++;

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint own_sum();
        longint s = 0;
        for (int k = 0; k < TAPS; k++) s += cm[k] * hist[k];
        return s;
    endfunction

    function automatic longint sec_sum();
        longint s = 0;
        for (int k = 0; k < TAPS; k++) s += cs[k] * hist[TAPS + k];
        return s;
    endfunction

    task automatic wcoef(input bit to_sec, input int idx, input longint val);
        @(negedge clk);
        cw_addr = ADDR_W'(idx);
        cw_data = coef_t'(val);
        if (to_sec) begin s_cw = 1'b1; cs[idx] = val; end
        else        begin m_cw = 1'b1; cm[idx] = val; end
        @(negedge clk);
        m_cw = 1'b0;
        s_cw = 1'b0;
    endtask

    // Push one sample and check outputs at t+2 and t+3.
    task automatic push(input smp_t x, input string req);
        longint exp;
        @(negedge clk);
        smp = x;
        vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        smp = 18'sh2AAAA;
        for (int i = 2*TAPS-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = longint'(x);
        if (mode == 2'b10) exp = own_sum() + sec_sum();
        else               exp = own_sum();
        @(negedge clk);
        check("R2 no early valid", longint'(m_yv), 0);
        check("R7 secondary partial sum", longint'(s_psum), sec_sum());
        @(negedge clk);
        check("R5 tap-out oldest stage", longint'(m_tap), hist[TAPS-1]);
        if (en) begin
            check({req, " valid at t+3 (R2)"}, longint'(m_yv), 1);
            check(req, longint'(m_y), exp);
        end else begin
            check("R8 disabled gives no valid", longint'(m_yv), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; vld = 1'b0; en = 1'b1; mode = 2'b00;
        smp = '0; m_cw = 1'b0; s_cw = 1'b0; cw_addr = '0; cw_data = '0;
        for (int i = 0; i < 2*TAPS; i++) hist[i] = 0;
        for (int k = 0; k < TAPS; k++) begin cm[k] = 0; cs[k] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset y", longint'(m_y), 0);
        check("R1 reset valid", longint'(m_yv), 0);
        check("R1 reset psum", longint'(m_psum), 0);
        check("R1 reset tap-out", longint'(m_tap), 0);

        // R4: single coefficient at bank 2 word 5 -> tap 37.
        wcoef(1'b0, 6'h25, 3);
        push(18'sd1000, "R4 impulse");
        for (int i = 0; i < 38; i++) push(18'sd0, "R4 impulse tail");

        // Full coefficient sets, then chained fill (R6) with R3 mix.
        for (int k = 0; k < TAPS; k++) begin
            wcoef(1'b0, k, ((k * 2731) % 4001) - 2000);
            wcoef(1'b1, k, ((k * 1877) % 3001) - 1500);
        end
        mode = 2'b10;
        for (int i = 0; i < 2*TAPS + 2; i++)
            push(smp_t'(((i * 9973) % 60001) - 30000), "R6 chained output");
        mode = 2'b00;
        for (int i = 0; i < 4; i++)
            push(smp_t'(((i * 7919) % 50001) - 25000), "R3 standalone output");

        // Stimulus table across roles and enable (R3 R6 R8 R11).
        for (int v = 0; v < 12; v++) begin
            mode = VEC[v].md;
            en   = VEC[v].ena;
            push(VEC[v].x, (VEC[v].md == 2'b10) ? "R6 table main" :
                           (VEC[v].md == 2'b11) ? "R11 table alt role" : "R3 table solo");
        end
        en = 1'b1;

        // R10: idle cycles with garbage data move nothing.
        mode = 2'b10;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            smp = smp_t'(i * 12345);
            @(negedge clk);
            check("R10 tap-out holds while idle", longint'(m_tap), hist[TAPS-1]);
        end
        push(18'sd222, "R10 output after idle");

        // R9: full-scale 128-tap corner.
        for (int k = 0; k < TAPS; k++) begin
            wcoef(1'b0, k, -131072);
            wcoef(1'b1, k, -131072);
        end
        for (int i = 0; i < 2*TAPS; i++) push(-18'sd131072, "R9 full-scale sum");
        check("R9 final value 2^41", longint'(m_y), 64'sd2199023255552);

        check("R7 secondary never valid", longint'(sec_pulses), 0);

        // R1: reset in the middle of operation.
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset y", longint'(m_y), 0);
        check("R1 mid-run reset psum", longint'(s_psum), 0);
        check("R1 mid-run reset tap-out", longint'(m_tap), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule